// File: doc/BRIEF.md
# Interleaved Grid Cluster Memory

This block stores a two-dimensional grid of 16-bit words and returns a fixed neighbourhood of seven grid words in one read. The caller supplies a base coordinate, and the block delivers the words at seven fixed offsets from that base. The grid is spread over a 4 by 4 array of independent RAM banks. Any 4 by 4 window of grid points therefore lands on sixteen distinct banks, and all sixteen can be read in the same cycle.

Each bank has its own address generator. For each axis, it adds one tile to the base tile index when the bank lies below the base's position inside its tile. This lets a cluster straddle tile boundaries. A routing stage then uses the base's low coordinate bits to send each bank's word to the cluster output that wants it. A separate single-word write port shares the banks through their second port, so writes and cluster reads proceed together.

Top module: `ilv_cluster_mem`

## Requirements
- R1: In the cycle after reset is released, `rd_valid` and `rd_err` are low and all seven cluster outputs are zero.
- R2: A write with `wr_en` high stores `wr_data` at grid point (`wr_x`, `wr_y`). Point (x, y) lives in bank (x mod 4, y mod 4) at local word (y div 4) * 38 + (x div 4). Later reads covering that point return the stored word.
- R3: A read strobe `rd_en` accepted on a clock edge raises `rd_valid` for exactly one cycle, after the second following edge. `rd_valid` is never high without such a strobe.
- R4: A base whose x or y coordinate is not a multiple of 4 still returns the correct words. For each axis, a bank whose index is below the base's low two bits reads the next tile.
- R5: A base with x above 147 or y above 72 gives `rd_valid` and `rd_err` high together, with all outputs zero. All outputs are also zero in every cycle where `rd_valid` is low.
- R6: Each output carries the word at the base plus its own (dx, dy) offset: `out_a2` (1,0), `out_a3` (2,0), `out_b1` (0,1), `out_b2` (1,1), `out_b3` (2,1), `out_c2` (1,2), `out_c3` (2,2).
- R7: A write and a read that touch the same grid word on the same edge do not interfere. The read returns the word held before that edge, and later reads return the new word.
- R8: While `wr_en` is low, changes on `wr_x`, `wr_y` and `wr_data` leave every stored word unchanged.
- R9: Reads strobed on consecutive cycles each return their own cluster, in the order issued, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Cluster read strobe |
| rd_x | input | 8 | Base x coordinate |
| rd_y | input | 7 | Base y coordinate |
| wr_en | input | 1 | Single-word write strobe |
| wr_x | input | 8 | Write x coordinate |
| wr_y | input | 7 | Write y coordinate |
| wr_data | input | 16 | Word to write |
| rd_valid | output | 1 | Cluster result present this cycle |
| rd_err | output | 1 | Result belongs to an out-of-range base |
| out_a2 | output | 16 | Word at offset (1,0) |
| out_a3 | output | 16 | Word at offset (2,0) |
| out_b1 | output | 16 | Word at offset (0,1) |
| out_b2 | output | 16 | Word at offset (1,1) |
| out_b3 | output | 16 | Word at offset (2,1) |
| out_c2 | output | 16 | Word at offset (1,2) |
| out_c3 | output | 16 | Word at offset (2,2) |

## Verification
The cluster read and the single-word write can hit the same bank and the same local word on one edge. The bench provokes this by strobing a read at a base while writing a fresh value to the point under `out_b2` on that same edge. It judges the result by checking that this read returns the old word, and that a read issued straight afterwards returns the new one. Aligned bases, tile-straddling bases, out-of-range bases and a back-to-back read stream are compared against a grid model kept in the bench.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
    // Fixed cluster shape: seven outputs and their offsets from the base.
    // Output order: a2, a3, b1, b2, b3, c2, c3.
    localparam int CL_N = 7;
    localparam int CL_DX [CL_N] = '{1, 2, 0, 1, 2, 1, 2};
    localparam int CL_DY [CL_N] = '{0, 0, 1, 1, 1, 2, 2};
    // Largest offset plus one in each axis; bounds the legal base.
    localparam int CL_SPAN = 3;
endpackage

// File: rtl/ilv_addr_gen.sv
`timescale 1ns/1ps
// Local word address for one bank, given the cluster base coordinate.
module ilv_addr_gen #(
    parameter int XW   = 8,
    parameter int YW   = 7,
    parameter int LB   = 2,
    parameter int COLS = 38,
    parameter int AW   = 10,
    parameter int BI   = 0,
    parameter int BJ   = 0
) (
    input  logic [XW-1:0] base_x,
    input  logic [YW-1:0] base_y,
    output logic [AW-1:0] addr
);
    logic [XW-1:0] col;
    logic [YW-1:0] row;

    always_comb begin
        col = base_x >> LB;
        row = base_y >> LB;
        // A bank sitting below the base inside the tile belongs to the next tile.
        if (LB'(BI) < base_x[LB-1:0]) col = col + XW'(1);
        if (LB'(BJ) < base_y[LB-1:0]) row = row + YW'(1);
        addr = AW'(row) * AW'(COLS) + AW'(col);
    end
endmodule

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
// One RAM bank: one write port, one registered read port, old data on a collision.
module ilv_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 722,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ilv_deint.sv
`timescale 1ns/1ps
// Routes each bank word to the cluster output whose grid offset it holds.
module ilv_deint
    import ilv_pkg::*;
#(
    parameter int DW = 16,
    parameter int LB = 2
) (
    input  logic [LB-1:0] lo_x,
    input  logic [LB-1:0] lo_y,
    input  logic [DW-1:0] bank_q [(1 << LB) * (1 << LB)],
    output logic [DW-1:0] clus   [CL_N]
);
    for (genvar k = 0; k < CL_N; k++) begin : g_out
        logic [LB-1:0] sx;
        logic [LB-1:0] sy;
        // Bank holding base + offset; the LB-bit add wraps modulo the bank count.
        assign sx = lo_x + LB'(CL_DX[k]);
        assign sy = lo_y + LB'(CL_DY[k]);
        assign clus[k] = bank_q[{sy, sx}];
    end
endmodule

// File: rtl/ilv_cluster_mem.sv
`timescale 1ns/1ps
module ilv_cluster_mem
    import ilv_pkg::*;
#(
    parameter int GRID_W = 150,
    parameter int GRID_H = 75,
    parameter int DW     = 16,
    parameter int LB     = 2,
    parameter int XW     = $clog2(GRID_W),
    parameter int YW     = $clog2(GRID_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [XW-1:0] rd_x,
    input  logic [YW-1:0] rd_y,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_x,
    input  logic [YW-1:0] wr_y,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic          rd_err,
    output logic [DW-1:0] out_a2,
    output logic [DW-1:0] out_a3,
    output logic [DW-1:0] out_b1,
    output logic [DW-1:0] out_b2,
    output logic [DW-1:0] out_b3,
    output logic [DW-1:0] out_c2,
    output logic [DW-1:0] out_c3
);
    localparam int NB    = 1 << LB;
    localparam int NBANK = NB * NB;
    // One spare tile per axis so a 4-wide window near the far edge stays in range.
    localparam int COLS  = GRID_W / NB + 1;
    localparam int ROWS  = GRID_H / NB + 1;
    localparam int DEPTH = COLS * ROWS;
    localparam int AW    = $clog2(DEPTH);
    localparam int X_MAX = GRID_W - CL_SPAN;
    localparam int Y_MAX = GRID_H - CL_SPAN;

    typedef struct packed {
        logic                     v1;
        logic                     e1;
        logic [LB-1:0]            lx;
        logic [LB-1:0]            ly;
        logic                     v2;
        logic                     e2;
        logic [CL_N-1:0][DW-1:0]  clus;
    } pipe_t;

    pipe_t st_d, st_q;

    logic          rd_ok_d;
    logic [XW-1:0] base_x_d;
    logic [YW-1:0] base_y_d;
    logic          wr_ok_d;
    logic [AW-1:0] waddr_d;
    logic [AW-1:0] raddr  [NBANK];
    logic [DW-1:0] bank_q [NBANK];
    logic [DW-1:0] clus_c [CL_N];
    logic [NBANK-1:0] wsel;

    // Request decode: illegal bases read bank word 0 and are flagged.
    always_comb begin
        rd_ok_d  = (rd_x <= XW'(X_MAX)) && (rd_y <= YW'(Y_MAX));
        base_x_d = rd_ok_d ? rd_x : '0;
        base_y_d = rd_ok_d ? rd_y : '0;
        wr_ok_d  = (wr_x < XW'(GRID_W)) && (wr_y < YW'(GRID_H));
        waddr_d  = AW'(wr_y >> LB) * AW'(COLS) + AW'(wr_x >> LB);
    end

    for (genvar gj = 0; gj < NB; gj++) begin : g_row
        for (genvar gi = 0; gi < NB; gi++) begin : g_col
            localparam int IDX = gj * NB + gi;

            ilv_addr_gen #(
                .XW(XW), .YW(YW), .LB(LB), .COLS(COLS), .AW(AW), .BI(gi), .BJ(gj)
            ) u_ag (
                .base_x (base_x_d),
                .base_y (base_y_d),
                .addr   (raddr[IDX])
            );

            assign wsel[IDX] = wr_en && wr_ok_d
                            && (wr_x[LB-1:0] == LB'(gi)) && (wr_y[LB-1:0] == LB'(gj));

            ilv_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
                .clk   (clk),
                .we    (wsel[IDX]),
                .waddr (waddr_d),
                .wdata (wr_data),
                .raddr (raddr[IDX]),
                .rdata (bank_q[IDX])
            );

            // R4: the +1 tile correction never leaves the bank
            p_raddr_in_bank_r4: assert property (@(posedge clk) disable iff (rst)
                rd_en |-> (raddr[IDX] < AW'(DEPTH)));
            // R2: an accepted write always targets a word inside the bank
            p_waddr_in_bank_r2: assert property (@(posedge clk) disable iff (rst)
                wsel[IDX] |-> (waddr_d < AW'(DEPTH)));
        end
    end

    ilv_deint #(.DW(DW), .LB(LB)) u_deint (
        .lo_x   (st_q.lx),
        .lo_y   (st_q.ly),
        .bank_q (bank_q),
        .clus   (clus_c)
    );

    // Next-state: stage 1 tracks the RAM access, stage 2 is the output register.
    always_comb begin
        st_d    = st_q;
        st_d.v1 = rd_en;
        st_d.e1 = rd_en && !rd_ok_d;
        st_d.lx = base_x_d[LB-1:0];
        st_d.ly = base_y_d[LB-1:0];
        st_d.v2 = st_q.v1;
        st_d.e2 = st_q.e1;
        for (int k = 0; k < CL_N; k++) begin
            st_d.clus[k] = (st_q.v1 && !st_q.e1) ? clus_c[k] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_valid = st_q.v2;
    assign rd_err   = st_q.e2;
    assign out_a2   = st_q.clus[0];
    assign out_a3   = st_q.clus[1];
    assign out_b1   = st_q.clus[2];
    assign out_b2   = st_q.clus[3];
    assign out_b3   = st_q.clus[4];
    assign out_c2   = st_q.clus[5];
    assign out_c3   = st_q.clus[6];

    // R1: nothing is reported right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_err));
    // R3: a strobe always yields a result two edges later
    p_strobe_latency_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ##1 rd_valid);
    // R3: no result appears without a strobe two edges earlier
    p_valid_has_source_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en, 2));
    // R5: an error result is a valid result with all words zero
    p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_valid && out_a2 == '0 && out_a3 == '0 && out_b1 == '0
                    && out_b2 == '0 && out_b3 == '0 && out_c2 == '0 && out_c3 == '0));
    // R5: outputs stay zero while no result is presented
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (out_a2 == '0 && out_b2 == '0 && out_c3 == '0));
endmodule

// File: tb/ilv_cluster_mem_tb_top.sv
`timescale 1ns/1ps
module ilv_cluster_mem_tb_top;
    localparam int W  = 150;
    localparam int H  = 75;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_x = '0;
    logic [6:0]  rd_y = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_x = '0;
    logic [6:0]  wr_y = '0;
    logic [15:0] wr_data = '0;
    logic        rd_valid, rd_err;
    logic [15:0] out_a2, out_a3, out_b1, out_b2, out_b3, out_c2, out_c3;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [0:W-1][0:H-1];
    int dxs [7] = '{1, 2, 0, 1, 2, 1, 2};
    int dys [7] = '{0, 0, 1, 1, 1, 2, 2};

    always #5 clk = ~clk;

    ilv_cluster_mem dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
        .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_err(rd_err),
        .out_a2(out_a2), .out_a3(out_a3), .out_b1(out_b1), .out_b2(out_b2),
        .out_b3(out_b3), .out_c2(out_c2), .out_c3(out_c3)
    );

    function automatic logic [15:0] out_k(int k);
        case (k)
            0: return out_a2;
            1: return out_a3;
            2: return out_b1;
            3: return out_b2;
            4: return out_b3;
            5: return out_c2;
            default: return out_c3;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All seven outputs against the model at base (bx, by).
    task automatic chk_cluster(string tag, int bx, int by);
        for (int k = 0; k < 7; k++) begin
            chk($sformatf("%s out%0d base(%0d,%0d)", tag, k, bx, by),
                32'(out_k(k)), 32'(model[bx + dxs[k]][by + dys[k]]));
        end
    endtask

    task automatic chk_zero(string tag);
        for (int k = 0; k < 7; k++) chk($sformatf("%s out%0d zero", tag, k), 32'(out_k(k)), 32'h0);
    endtask

    // Single read; checks the quiet cycle and then the result.
    task automatic rd_one(string tag, int bx, int by, bit bad);
        @(negedge clk);
        rd_en = 1'b1; rd_x = 8'(bx); rd_y = 7'(by);
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " R3 valid low after one edge"}, 32'(rd_valid), 32'h0);
        @(negedge clk);
        chk({tag, " R3 valid after two edges"}, 32'(rd_valid), 32'h1);
        chk({tag, " R5 err flag"}, 32'(rd_err), 32'(bad));
        if (bad) chk_zero({tag, " R5"});
        else     chk_cluster(tag, bx, by);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(rd_valid), 32'h0);
        chk("R1 err after reset", 32'(rd_err), 32'h0);
        chk_zero("R1");
    endtask

    task automatic t_fill;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_x = 8'(x); wr_y = 7'(y);
                wr_data = {x[7:0], y[7:0]} ^ 16'h5a00;
                model[x][y] = {x[7:0], y[7:0]} ^ 16'h5a00;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_aligned;
        rd_one("R6 R2 aligned", 0, 0, 1'b0);
        rd_one("R6 R2 aligned", 4, 8, 1'b0);
        rd_one("R6 R2 aligned", 144, 68, 1'b0);
    endtask

    task automatic t_wrap;
        rd_one("R4 wrap", 1, 0, 1'b0);
        rd_one("R4 wrap", 3, 3, 1'b0);
        rd_one("R4 wrap", 2, 5, 1'b0);
        rd_one("R4 wrap", 145, 71, 1'b0);
        rd_one("R4 wrap edge", 147, 72, 1'b0);
    endtask

    task automatic t_err;
        rd_one("R5 x over", 148, 0, 1'b1);
        rd_one("R5 y over", 0, 73, 1'b1);
        rd_one("R5 both over", 255, 127, 1'b1);
    endtask

    task automatic t_stream;
        int sx [6] = '{0, 1, 2, 3, 40, 99};
        int sy [6] = '{0, 7, 13, 2, 50, 30};
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                chk($sformatf("R9 stream valid %0d", c - 2), 32'(rd_valid), 32'h1);
                chk_cluster("R9 stream", sx[c - 2], sy[c - 2]);
            end
            if (c < 6) begin
                rd_en = 1'b1; rd_x = 8'(sx[c]); rd_y = 7'(sy[c]);
            end else begin
                rd_en = 1'b0;
            end
        end
        @(negedge clk);
        chk("R9 stream ends", 32'(rd_valid), 32'h0);
    endtask

    task automatic t_collide;
        logic [15:0] old_w;
        old_w = model[21][11];
        @(negedge clk);
        rd_en = 1'b1; rd_x = 8'd20; rd_y = 7'd10;
        wr_en = 1'b1; wr_x = 8'd21; wr_y = 7'd11; wr_data = 16'hbeef;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R7 collide read sees old word", 32'(out_b2), 32'(old_w));
        chk("R7 collide valid", 32'(rd_valid), 32'h1);
        model[21][11] = 16'hbeef;
        rd_one("R7 after collide", 20, 10, 1'b0);
    endtask

    task automatic t_wr_off;
        @(negedge clk);
        wr_en = 1'b0; wr_x = 8'd61; wr_y = 7'd31; wr_data = 16'h1234;
        @(negedge clk);
        wr_x = 8'd62; wr_data = 16'h4321;
        @(negedge clk);
        rd_one("R8 wr_en low", 60, 30, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_aligned();
        t_wrap();
        t_err();
        t_stream();
        t_collide();
        t_wr_off();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule